// File: doc/BRIEF.md
# Per-CPU Interval Tick Skip Counter

This block lets each of four processors skip a programmable number of periodic timer ticks. Each processor owns one down-counter with a 24-bit count field and a sticky underflow flag above it. Software loads a counter with the number of ticks to skip. Every rising edge of a shared, asynchronous tick line decrements all counters once. When a counter runs past zero, its flag sets. From that tick on, the processor receives a timer event on every tick.

The count keeps running after underflow. Software can read the remaining count and work out how many ticks went by unserviced. Any write to a counter reloads it and clears its flag. The timer event is a one-cycle pulse per processor. It is meant to set that processor's pending bit and raise its timer interrupt in the surrounding status logic.

Top module: `interval_skip_counter`

## Requirements
- R1: After reset, every counter reads zero and no timer event is asserted.
- R2: A write to offset 0x380, 0x3C0, 0x700 or 0x740 loads the counter of CPU0, CPU1, CPU2 or CPU3 respectively with write-data bits [23:0]. A read at the same offset returns the 25-bit counter (flag in bit 24) zero-extended to 64 bits.
- R3: A write always leaves bit 24 (the underflow flag) clear, even when the written data has bit 24 set or the flag was set before.
- R4: Each rising edge of the tick input decrements every counter's 24-bit count exactly once, however long the input stays high.
- R5: Decrementing a count of zero gives 0xFFFFFF in bits [23:0] and sets bit 24.
- R6: Once set, bit 24 stays set across later ticks, and the count field keeps decrementing.
- R7: After each tick's update, every CPU whose bit 24 is set gets a timer event lasting exactly one clock cycle. CPUs with bit 24 clear get none, and no event occurs without a tick.
- R8: A falling edge of the tick input changes no counter and causes no event.
- R9: When a write and a tick update fall in the same cycle, the written counter takes the written value and is not decremented. The other counters still decrement.
- R10: A write to an offset that is not one of the four counters changes no counter, and a read from such an offset returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_in | input | 1 | Asynchronous periodic tick; rising edges act |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Write byte offset |
| wr_data | input | 64 | Write data |
| rd_addr | input | 12 | Read byte offset |
| rd_data | output | 64 | Read data for rd_addr, combinational |
| tmr_event | output | 4 | Per-CPU one-cycle timer event pulse |

## Verification
The counters are loaded with a mix of values: some counters start at zero, some a few ticks from zero, and one is written with bit 24 set. A single tick then separates a plain decrement from a wrap, and shows whether a written flag bit is stored. A long-held tick level separates edge detection from level sensing, and the falling edge that follows shows whether it is ignored. Repeated ticks after underflow show whether the flag is sticky while the count runs on and one event arrives per tick. A write placed in the exact cycle of a tick update, and a write to a neighbouring unmapped offset, check that writes take priority and that address decoding is exact.

// File: rtl/isc_pkg.sv
package isc_pkg;
   localparam int MAX_CPU = 4;

   // Byte offset of the counter register owned by CPU idx.
   function automatic logic [11:0] slot_offset(input int idx);
      if (idx < 2) return 12'h380 + 12'(idx) * 12'h040;
      else         return 12'h700 + 12'(idx - 2) * 12'h040;
   endfunction
endpackage

// File: rtl/isc_tick_edge.sv
module isc_tick_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_async,
   output logic tick_pulse
);
   logic [STAGES-1:0] sync_q;
   logic              last_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("isc_tick_edge: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sync_q <= '0;
         last_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], tick_async};
         last_q <= sync_q[STAGES-1];
      end
   end

   assign tick_pulse = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/isc_slot.sv
module isc_slot #(
   parameter int CNT_W = 24
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           tick,
   input  logic           load,
   input  logic [CNT_W-1:0] ld_val,
   output logic [CNT_W:0] val_q,
   output logic           evt_q
);
   logic [CNT_W:0] diff;
   logic [CNT_W:0] dec_val;

   always_comb begin
      diff    = val_q - 1'b1;
      dec_val = {diff[CNT_W] | val_q[CNT_W], diff[CNT_W-1:0]};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         val_q <= '0;
         evt_q <= 1'b0;
      end else begin
         evt_q <= 1'b0;
         if (load) begin
            val_q <= {1'b0, ld_val};
         end else if (tick) begin
            val_q <= dec_val;
            evt_q <= dec_val[CNT_W];
         end
      end
   end
endmodule

// File: rtl/isc_rd_mux.sv
module isc_rd_mux
   import isc_pkg::*;
#(
   parameter int NUM_CPU = 4,
   parameter int CNT_W   = 24,
   parameter int ADDR_W  = 12,
   parameter int DATA_W  = 64
) (
   input  logic [ADDR_W-1:0]            rd_addr,
   input  logic [NUM_CPU-1:0][CNT_W:0]  slot_val,
   output logic [DATA_W-1:0]            rd_data
);
   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NUM_CPU; i++) begin
         if (rd_addr == ADDR_W'(slot_offset(i)))
            rd_data = DATA_W'(slot_val[i]);
      end
   end
endmodule

// File: rtl/interval_skip_counter.sv
module interval_skip_counter
   import isc_pkg::*;
#(
   parameter int NUM_CPU     = 4,
   parameter int CNT_W       = 24,
   parameter int ADDR_W      = 12,
   parameter int DATA_W      = 64,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick_in,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   wr_addr,
   input  logic [DATA_W-1:0]   wr_data,
   input  logic [ADDR_W-1:0]   rd_addr,
   output logic [DATA_W-1:0]   rd_data,
   output logic [NUM_CPU-1:0]  tmr_event
);
   generate
      if (NUM_CPU < 1 || NUM_CPU > MAX_CPU) begin : g_bad_cpu
         $error("interval_skip_counter: NUM_CPU out of range");
      end
      if (DATA_W <= CNT_W) begin : g_bad_data
         $error("interval_skip_counter: DATA_W must exceed CNT_W");
      end
      if (ADDR_W < 12) begin : g_bad_addr
         $error("interval_skip_counter: ADDR_W too narrow for offsets");
      end
   endgenerate

   logic                          tick_pulse;
   logic [NUM_CPU-1:0]            wr_hit;
   logic [NUM_CPU-1:0][CNT_W:0]   slot_val;
   logic                          unused_wr_hi;

   assign unused_wr_hi = ^wr_data[DATA_W-1:CNT_W];

   isc_tick_edge #(.STAGES(SYNC_STAGES)) tick_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_async (tick_in),
      .tick_pulse (tick_pulse)
   );

   for (genvar g = 0; g < NUM_CPU; g++) begin : g_slot
      assign wr_hit[g] = wr_en && (wr_addr == ADDR_W'(slot_offset(g)));

      isc_slot #(.CNT_W(CNT_W)) slot_i (
         .clk    (clk),
         .rst_n  (rst_n),
         .tick   (tick_pulse),
         .load   (wr_hit[g]),
         .ld_val (wr_data[CNT_W-1:0]),
         .val_q  (slot_val[g]),
         .evt_q  (tmr_event[g])
      );
   end

   isc_rd_mux #(
      .NUM_CPU (NUM_CPU),
      .CNT_W   (CNT_W),
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W)
   ) rd_i (
      .rd_addr  (rd_addr),
      .slot_val (slot_val),
      .rd_data  (rd_data)
   );
endmodule

// File: rtl/isc_checker.sv
module isc_checker #(
   parameter int NUM_CPU = 4,
   parameter int CNT_W   = 24
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         tick_pulse,
   input logic [NUM_CPU-1:0]           wr_hit,
   input logic [NUM_CPU-1:0][CNT_W:0]  slot_val,
   input logic [NUM_CPU-1:0]           tmr_event
);
   for (genvar g = 0; g < NUM_CPU; g++) begin : g_chk
      // R7: an event only accompanies a set flag
      a_r7_event_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
         tmr_event[g] |-> slot_val[g][CNT_W]);
      // R7: no event in the cycle after a cycle without a tick
      a_r7_event_only_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
         !tick_pulse |=> !tmr_event[g]);
      // R6: flag survives anything except a write
      a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
         (slot_val[g][CNT_W] && !wr_hit[g]) |=> slot_val[g][CNT_W]);
      // R3: a write leaves the flag clear
      a_r3_write_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
         wr_hit[g] |=> !slot_val[g][CNT_W]);
      // R4/R8: no change without a tick or a write
      a_r4_stable_without_cause: assert property (@(posedge clk) disable iff (!rst_n)
         (!tick_pulse && !wr_hit[g]) |=> $stable(slot_val[g]));
   end
endmodule

bind interval_skip_counter isc_checker #(
   .NUM_CPU (NUM_CPU),
   .CNT_W   (CNT_W)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .tick_pulse (tick_pulse),
   .wr_hit     (wr_hit),
   .slot_val   (slot_val),
   .tmr_event  (tmr_event)
);

// File: tb/interval_skip_counter_tb_top.sv
module interval_skip_counter_tb_top;
   localparam int N = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_in = 1'b0;
   logic        wr_en = 1'b0;
   logic [11:0] wr_addr = '0;
   logic [63:0] wr_data = '0;
   logic [11:0] rd_addr = '0;
   logic [63:0] rd_data;
   logic [N-1:0] tmr_event;

   int checks = 0;
   int errors = 0;
   int evt_cnt [N];
   int exp_evt [N];
   logic [24:0] exp_val [N];
   logic [11:0] offs [N] = '{12'h380, 12'h3C0, 12'h700, 12'h740};

   always #4 clk = ~clk;

   interval_skip_counter dut_i (
      .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
      .rd_data(rd_data), .tmr_event(tmr_event)
   );

   // count event pulses away from the active edge
   always @(negedge clk) begin
      for (int i = 0; i < N; i++)
         if (rst_n && tmr_event[i]) evt_cnt[i]++;
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [24:0] model_dec(input logic [24:0] v);
      logic [24:0] d;
      d = v - 25'd1;
      return {d[24] | v[24], d[23:0]};
   endfunction

   task automatic reg_write(input logic [11:0] a, input logic [63:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic check_all(input string req);
      for (int i = 0; i < N; i++) begin
         rd_addr = offs[i];
         #1;
         chk(rd_data == {39'd0, exp_val[i]}, req, rd_data, {39'd0, exp_val[i]});
         chk(evt_cnt[i] == exp_evt[i], {req, " events"}, evt_cnt[i], exp_evt[i]);
      end
   endtask

   task automatic model_tick(input int skip);
      for (int i = 0; i < N; i++) begin
         if (i != skip) begin
            exp_val[i] = model_dec(exp_val[i]);
            if (exp_val[i][24]) exp_evt[i]++;
         end
      end
   endtask

   task automatic one_tick();
      @(negedge clk); tick_in = 1'b1;
      repeat (4) @(negedge clk);
      tick_in = 1'b0;
      repeat (4) @(negedge clk);
      model_tick(-1);
   endtask

   task automatic t_reset();
      check_all("R1");
      chk(tmr_event == '0, "R1 idle", tmr_event, 0);
   endtask

   task automatic t_load();
      reg_write(12'h380, 64'h0000_0000_0000_0003); exp_val[0] = 25'h3;
      reg_write(12'h3C0, 64'hFFFF_FFFF_FE00_0010); exp_val[1] = 25'h10;
      reg_write(12'h700, 64'h0000_0000_0100_0005); exp_val[2] = 25'h5;
      reg_write(12'h740, 64'h0000_0000_0000_0000); exp_val[3] = 25'h0;
      check_all("R2 R3 load");
   endtask

   task automatic t_first_tick();
      one_tick();
      check_all("R4 R5 R7 first tick");
   endtask

   task automatic t_hold_high();
      @(negedge clk); tick_in = 1'b1;
      repeat (20) @(negedge clk);
      model_tick(-1);
      check_all("R4 held high");
      tick_in = 1'b0;
      repeat (20) @(negedge clk);
      check_all("R8 falling edge");
   endtask

   task automatic t_sticky();
      one_tick();
      check_all("R6 R7 tick a");
      one_tick();
      check_all("R5 R6 R7 tick b");
   endtask

   task automatic t_write_clears();
      reg_write(12'h740, 64'h0000_0000_0100_0002); exp_val[3] = 25'h2;
      check_all("R3 reload");
      one_tick();
      check_all("R3 R7 after reload");
   endtask

   task automatic t_same_cycle();
      @(negedge clk); tick_in = 1'b1;
      @(negedge clk);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 12'h3C0; wr_data = 64'h00AB_CDEF;
      @(negedge clk);
      wr_en = 1'b0;
      repeat (3) @(negedge clk);
      tick_in = 1'b0;
      repeat (4) @(negedge clk);
      model_tick(1);
      exp_val[1] = 25'hABCDEF;
      check_all("R9 write priority");
   endtask

   task automatic t_unmapped();
      reg_write(12'h384, 64'h55);
      reg_write(12'h000, 64'h77);
      check_all("R10 unmapped write");
      rd_addr = 12'h384;
      #1;
      chk(rd_data == 64'd0, "R10 unmapped read", rd_data, 0);
   endtask

   initial begin
      for (int i = 0; i < N; i++) begin
         evt_cnt[i] = 0; exp_evt[i] = 0; exp_val[i] = '0;
      end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_load();
      t_first_tick();
      t_hold_high();
      t_sticky();
      t_write_clears();
      t_same_cycle();
      t_unmapped();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 100000);
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule